// File: doc/BRIEF.md
# Banked Memory Controller with Open-Row Tracking

This block sits between a single requesting master and four external memory banks: two read-only banks (a boot bank and a cartridge bank) and two dynamic RAM banks. Each accepted access carries the upper address bits above a 4 KB page offset, a read/write flag and eight byte enables. The block works out which bank the address falls in and drives that bank's select for a number of clock cycles. It then pulses a completion strobe in the last cycle. The requester waits for this strobe before it asks again.

Out of reset the controller is unconfigured. Every address then lands in the boot bank, so the boot code can be fetched wherever the processor starts. A write to the configuration inputs marks the controller configured and selects one of two address layouts. The same write sets the read-only wait count and the dynamic RAM row-open delay. For dynamic RAM the block remembers which bank and row are open. An access to the open row gets a short two-cycle column cycle. Any other dynamic RAM access first opens the row and then runs the column cycle. Read output enables and write strobes are derived from the byte enables of the access.

Top module: `banked_mem_ctrl`

## Requirements
- R1: While reset is held, and after it until the first request, every chip select, strobe, enable and `done` is 0. Reset leaves the controller unconfigured, with a read-only wait of 7 and a row delay of 7.
- R2: While unconfigured, every address selects the boot bank (`rom_cs[0]`).
- R3: Once configured with `cfg_map_hi`=1, the banks lie as follows. Addresses 000000–3FFFFF go to DRAM bank 0 (`ras[0]`/`cas[0]`). 400000–7FFFFF go to DRAM bank 1 (bit 1). 800000–DFFFFF go to the cartridge bank (`rom_cs[1]`). E00000–FFFFFF go to the boot bank.
- R4: Once configured with `cfg_map_hi`=0, the boot bank covers 000000–1FFFFF and the cartridge bank 200000–7FFFFF. DRAM bank 1 covers 800000–BFFFFF and DRAM bank 0 covers C00000–FFFFFF.
- R5: A read-only bank access holds its `rom_cs` bit for W+1 cycles, where W is the configured 4-bit wait (0–15). These cycles start on the cycle after `req` is sampled.
- R6: A DRAM access that misses first spends D cycles with only `ras` of its bank set. It then spends 2 cycles with `cas` set as well. D is the 3-bit row delay field, and values below 3 act as 3.
- R7: A DRAM access whose bank is open and whose row (address bits 21:12) equals the open row runs only the 2 `cas` cycles.
- R8: A bank's `ras` stays set between accesses while its row is open. The open row is dropped by reset, by any configuration write, by any read-only access and by an access to the other DRAM bank. After it is dropped, the next access to that bank misses.
- R9: On a DRAM write, `wr_strb` equals `acc_be` during the two `cas` cycles and is 0 otherwise. Writes to read-only banks never assert `wr_strb`.
- R10: On reads, `oe` is set during read-only select cycles and during `cas` cycles. `oe[0]` is the OR of byte enables 1:0, `oe[1]` the OR of 3:2 and `oe[2]` the OR of 7:4. Writes never assert `oe`.
- R11: `done` is high for exactly one cycle, the last select cycle of each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_map_hi | input | 1 | Layout select written on `cfg_we` |
| cfg_rom_wait | input | 4 | Read-only wait count written on `cfg_we` |
| cfg_row_wait | input | 3 | Row-open delay written on `cfg_we` |
| req | input | 1 | Start an access (sampled when idle) |
| acc_addr | input | 12 | Address bits 23:12 of the access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_be | input | 8 | Byte enables of the 64-bit access |
| rom_cs | output | 2 | Read-only selects: bit 0 boot, bit 1 cartridge |
| ras | output | 2 | Row strobe per DRAM bank |
| cas | output | 2 | Column strobe per DRAM bank |
| wr_strb | output | 8 | Per-byte write strobes |
| oe | output | 3 | Output enables for bits 15:0, 31:16, 63:32 |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions rely on two things about the inputs. `req` only arrives while no access is in flight, that is, after the previous `done`. `cfg_we` never coincides with `req` or with an access in flight. Under those conditions, `cas` always sits on a bank whose `ras` is set, and strobes appear only inside select cycles. The stimulus raises `req` for one cycle only, and only after the completion strobe and one idle cycle. It writes the configuration only in idle cycles with `req` low. This keeps every sequence within what the checker presumes.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    localparam int ROMW_W = 4;
    localparam int ROWW_W = 3;
    localparam int CNT_W  = 4;
    localparam int MIN_ROW_WAIT = 3;

    typedef enum logic [1:0] {
        BK_ROM0  = 2'd0,
        BK_ROM1  = 2'd1,
        BK_DRAM0 = 2'd2,
        BK_DRAM1 = 2'd3
    } bank_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ROM,
        SQ_ROW,
        SQ_PAGE
    } seq_e;

    typedef struct packed {
        logic              configured;
        logic              map_hi;
        logic [ROMW_W-1:0] rom_wait;
        logic [ROWW_W-1:0] row_wait;
    } cfg_t;

    function automatic logic is_dram(input bank_e b);
        return b[1];
    endfunction

    function automatic logic [2:0] oe_groups(input logic [7:0] be);
        return {|be[7:4], |be[3:2], |be[1:0]};
    endfunction

    function automatic logic [CNT_W-1:0] row_delay(input logic [ROWW_W-1:0] w);
        return (w < ROWW_W'(MIN_ROW_WAIT)) ? CNT_W'(MIN_ROW_WAIT) : CNT_W'(w);
    endfunction

endpackage

// File: rtl/mbc_decode.sv
module mbc_decode
    import mbc_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int PAGE_BITS = 12,
    localparam int ROW_W    = ADDR_W - 2 - PAGE_BITS
) (
    input  logic [ADDR_W-1:PAGE_BITS] addr,
    input  cfg_t                      cfg,
    output bank_e                     bank,
    output logic [ROW_W-1:0]          row
);
    logic [2:0] top3;
    assign top3 = addr[ADDR_W-1:ADDR_W-3];
    assign row  = addr[ADDR_W-3:PAGE_BITS];

    always_comb begin
        if (!cfg.configured) begin
            bank = BK_ROM0;
        end else if (cfg.map_hi) begin
            unique case (top3)
                3'b000, 3'b001: bank = BK_DRAM0;
                3'b010, 3'b011: bank = BK_DRAM1;
                3'b100, 3'b101, 3'b110: bank = BK_ROM1;
                default: bank = BK_ROM0;
            endcase
        end else begin
            unique case (top3)
                3'b000: bank = BK_ROM0;
                3'b001, 3'b010, 3'b011: bank = BK_ROM1;
                3'b100, 3'b101: bank = BK_DRAM1;
                default: bank = BK_DRAM0;
            endcase
        end
    end
endmodule

// File: rtl/mbc_page_track.sv
module mbc_page_track
    import mbc_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  bank_e            bank,
    input  logic [ROW_W-1:0] row,
    output logic             hit,
    output logic [1:0]       ras
);
    logic             open_q;
    logic             open_bank_q;
    logic [ROW_W-1:0] open_row_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            open_q      <= 1'b0;
            open_bank_q <= 1'b0;
            open_row_q  <= '0;
        end else if (load) begin
            open_q      <= is_dram(bank);
            open_bank_q <= bank[0];
            open_row_q  <= row;
        end
    end

    assign hit = open_q && is_dram(bank) && (open_bank_q == bank[0]) && (open_row_q == row);
    assign ras = open_q ? (2'b01 << open_bank_q) : 2'b00;
endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
    import mbc_pkg::*;
#(
    parameter int BYTES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  bank_e            bank,
    input  logic             hit,
    input  logic             wr,
    input  logic [BYTES-1:0] be,
    input  cfg_t             cfg,
    output logic             busy,
    output logic [1:0]       rom_cs,
    output logic [1:0]       cas,
    output logic [BYTES-1:0] wr_strb,
    output logic [2:0]       oe,
    output logic             done
);
    seq_e             st_q;
    logic [CNT_W-1:0] cnt_q;
    bank_e            bank_q;
    logic             wr_q;
    logic [BYTES-1:0] be_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            cnt_q  <= '0;
            bank_q <= BK_ROM0;
            wr_q   <= 1'b0;
            be_q   <= '0;
        end else begin
            unique case (st_q)
                SQ_IDLE: if (start) begin
                    bank_q <= bank;
                    wr_q   <= wr;
                    be_q   <= be;
                    if (!is_dram(bank)) begin
                        st_q  <= SQ_ROM;
                        cnt_q <= CNT_W'(cfg.rom_wait);
                    end else if (hit) begin
                        st_q  <= SQ_PAGE;
                        cnt_q <= CNT_W'(1);
                    end else begin
                        st_q  <= SQ_ROW;
                        cnt_q <= row_delay(cfg.row_wait) - CNT_W'(1);
                    end
                end
                SQ_ROM: begin
                    if (cnt_q == '0) st_q <= SQ_IDLE;
                    else             cnt_q <= cnt_q - CNT_W'(1);
                end
                SQ_ROW: begin
                    if (cnt_q == '0) begin
                        st_q  <= SQ_PAGE;
                        cnt_q <= CNT_W'(1);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: begin
                    if (cnt_q == '0) st_q <= SQ_IDLE;
                    else             cnt_q <= cnt_q - CNT_W'(1);
                end
            endcase
        end
    end

    logic in_rom, in_page;
    assign in_rom  = (st_q == SQ_ROM);
    assign in_page = (st_q == SQ_PAGE);

    assign busy    = (st_q != SQ_IDLE);
    assign rom_cs  = in_rom  ? (2'b01 << bank_q[0]) : 2'b00;
    assign cas     = in_page ? (2'b01 << bank_q[0]) : 2'b00;
    assign wr_strb = (in_page && wr_q) ? be_q : '0;
    assign oe      = ((in_rom || in_page) && !wr_q) ? oe_groups(be_q) : 3'b000;
    assign done    = (in_rom || in_page) && (cnt_q == '0);
endmodule

// File: rtl/banked_mem_ctrl.sv
module banked_mem_ctrl
    import mbc_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int PAGE_BITS = 12,
    parameter int BYTES     = 8,
    localparam int ROW_W    = ADDR_W - 2 - PAGE_BITS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic                      cfg_map_hi,
    input  logic [ROMW_W-1:0]         cfg_rom_wait,
    input  logic [ROWW_W-1:0]         cfg_row_wait,
    input  logic                      req,
    input  logic [ADDR_W-1:PAGE_BITS] acc_addr,
    input  logic                      acc_wr,
    input  logic [BYTES-1:0]          acc_be,
    output logic [1:0]                rom_cs,
    output logic [1:0]                ras,
    output logic [1:0]                cas,
    output logic [BYTES-1:0]          wr_strb,
    output logic [2:0]                oe,
    output logic                      done
);
    cfg_t             cfg_q;
    bank_e            dec_bank;
    logic [ROW_W-1:0] dec_row;
    logic             row_hit;
    logic             busy;
    logic             accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{configured: 1'b0, map_hi: 1'b1,
                       rom_wait: ROMW_W'(7), row_wait: ROWW_W'(7)};
        end else if (cfg_we) begin
            cfg_q <= '{configured: 1'b1, map_hi: cfg_map_hi,
                       rom_wait: cfg_rom_wait, row_wait: cfg_row_wait};
        end
    end

    assign accept = req && !busy && !cfg_we;

    mbc_decode #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_dec (
        .addr (acc_addr),
        .cfg  (cfg_q),
        .bank (dec_bank),
        .row  (dec_row)
    );

    mbc_page_track #(.ROW_W(ROW_W)) u_trk (
        .clk   (clk),
        .rst   (rst),
        .clear (cfg_we),
        .load  (accept),
        .bank  (dec_bank),
        .row   (dec_row),
        .hit   (row_hit),
        .ras   (ras)
    );

    mbc_seq #(.BYTES(BYTES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .bank    (dec_bank),
        .hit     (row_hit),
        .wr      (acc_wr),
        .be      (acc_be),
        .cfg     (cfg_q),
        .busy    (busy),
        .rom_cs  (rom_cs),
        .cas     (cas),
        .wr_strb (wr_strb),
        .oe      (oe),
        .done    (done)
    );
endmodule

// File: rtl/mbc_checker.sv
module mbc_checker (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [1:0] rom_cs,
    input logic [1:0] ras,
    input logic [1:0] cas,
    input logic [7:0] wr_strb,
    input logic [2:0] oe,
    input logic       done
);
    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_in_select_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (rom_cs != 2'b00 || cas != 2'b00));

    assert_cas_under_ras_R6: assert property (@(posedge clk) disable iff (rst)
        (cas != 2'b00) |-> ((cas & ras) == cas && $onehot0(cas)));

    assert_rom_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        (rom_cs != 2'b00) |-> ($onehot0(rom_cs) && ras == 2'b00 && cas == 2'b00));

    assert_cfg_closes_row_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (ras == 2'b00));

    assert_strobe_in_cas_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_strb != 8'h00) |-> (cas != 2'b00 && oe == 3'b000));

    assert_oe_in_select_R10: assert property (@(posedge clk) disable iff (rst)
        (oe != 3'b000) |-> (rom_cs != 2'b00 || cas != 2'b00));
endmodule

bind banked_mem_ctrl mbc_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .rom_cs  (rom_cs),
    .ras     (ras),
    .cas     (cas),
    .wr_strb (wr_strb),
    .oe      (oe),
    .done    (done)
);

// File: tb/banked_mem_ctrl_tb.sv
module banked_mem_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic        cfg_map_hi;
    logic [3:0]  cfg_rom_wait;
    logic [2:0]  cfg_row_wait;
    logic        req;
    logic [11:0] acc_addr;
    logic        acc_wr;
    logic [7:0]  acc_be;
    logic [1:0]  rom_cs, ras, cas;
    logic [7:0]  wr_strb;
    logic [2:0]  oe;
    logic        done;

    int total = 0;
    int bad   = 0;

    // reference state
    bit m_cfgd;
    bit m_hi;
    int m_romw;
    int m_roww;
    bit m_open;
    int m_obank;
    int m_orow;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_mem_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_map_hi(cfg_map_hi),
        .cfg_rom_wait(cfg_rom_wait), .cfg_row_wait(cfg_row_wait),
        .req(req), .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_be(acc_be),
        .rom_cs(rom_cs), .ras(ras), .cas(cas), .wr_strb(wr_strb),
        .oe(oe), .done(done)
    );

    // 0 boot, 1 cartridge, 2 dram0, 3 dram1
    function automatic int ref_bank(input int a);
        if (!m_cfgd) return 0;
        if (m_hi) begin
            if (a < 'h400000) return 2;
            if (a < 'h800000) return 3;
            if (a < 'hE00000) return 1;
            return 0;
        end
        if (a < 'h200000) return 0;
        if (a < 'h800000) return 1;
        if (a < 'hC00000) return 3;
        return 2;
    endfunction

    function automatic logic [2:0] ref_oe(input logic [7:0] b);
        logic [2:0] r;
        r[0] = (b & 8'h03) != 0;
        r[1] = (b & 8'h0C) != 0;
        r[2] = (b & 8'hF0) != 0;
        return r;
    endfunction

    function automatic logic [1:0] open_ras();
        if (!m_open) return 2'b00;
        return (m_obank == 0) ? 2'b01 : 2'b10;
    endfunction

    task automatic check(input logic [1:0] e_rom, input logic [1:0] e_ras,
                         input logic [1:0] e_cas, input logic [7:0] e_we,
                         input logic [2:0] e_oe, input logic e_done,
                         input string tag);
        logic [17:0] act, exp;
        act = {rom_cs, ras, cas, wr_strb, oe, done};
        exp = {e_rom, e_ras, e_cas, e_we, e_oe, e_done};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0t actual={cs,ras,cas,we,oe,done}=%h expected=%h",
                     tag, $time, act, exp);
        end
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        check(2'b00, open_ras(), 2'b00, 8'h00, 3'b000, 1'b0, tag);
    endtask

    task automatic configure(input bit hi, input int romw, input int roww);
        cfg_we = 1'b1; cfg_map_hi = hi;
        cfg_rom_wait = 4'(romw); cfg_row_wait = 3'(roww);
        @(negedge clk);
        cfg_we = 1'b0;
        m_cfgd = 1'b1; m_hi = hi; m_romw = romw;
        m_roww = (roww < 3) ? 3 : roww;
        m_open = 1'b0;  // R8: configuration closes the row
        check(2'b00, 2'b00, 2'b00, 8'h00, 3'b000, 1'b0, "R8 cfg");
    endtask

    // Called at a negedge; drives one request and checks every following cycle.
    task automatic access(input int a, input bit w, input logic [7:0] b, input string tag);
        int bk, row, len, pre;
        logic [1:0] sel;
        bk  = ref_bank(a);
        row = (a % 'h400000) / 'h1000;
        sel = (bk == 0 || bk == 2) ? 2'b01 : 2'b10;
        if (bk < 2) begin
            len = m_romw + 1; pre = 0;
            m_open = 1'b0;
        end else if (m_open && m_obank == bk - 2 && m_orow == row) begin
            len = 2; pre = 0;
        end else begin
            pre = m_roww; len = pre + 2;
            m_open = 1'b1; m_obank = bk - 2; m_orow = row;
        end
        req = 1'b1; acc_addr = 12'(a / 'h1000); acc_wr = w; acc_be = b;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            req = 1'b0;
            if (bk < 2)
                check(sel, 2'b00, 2'b00, 8'h00, w ? 3'b000 : ref_oe(b),
                      i == len - 1, tag);
            else if (i < pre)
                check(2'b00, sel, 2'b00, 8'h00, 3'b000, 1'b0, tag);
            else
                check(2'b00, sel, sel, w ? b : 8'h00, w ? 3'b000 : ref_oe(b),
                      i == len - 1, tag);
        end
        idle_check({tag, " idle"});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_map_hi = 1'b0; cfg_rom_wait = '0;
        cfg_row_wait = '0; req = 1'b0; acc_addr = '0; acc_wr = 1'b0; acc_be = '0;
        m_cfgd = 1'b0; m_hi = 1'b1; m_romw = 7; m_roww = 7; m_open = 1'b0;
        m_obank = 0; m_orow = 0;
        repeat (3) @(negedge clk);
        check(2'b00, 2'b00, 2'b00, 8'h00, 3'b000, 1'b0, "R1 in reset");
        rst = 1'b0;
        idle_check("R1 after reset");

        // R2 boot window mirrored, R5 default wait 7, R10 enable groups
        access('h000000, 1'b0, 8'hFF, "R2 R5 mirror low");
        access('h7FF000, 1'b0, 8'h03, "R2 R10 mirror mid");
        access('hFFF000, 1'b0, 8'h30, "R2 R10 mirror top");
        access('h400000, 1'b1, 8'hFF, "R2 R9 rom write");

        // R3 layout, row delay 5
        configure(1'b1, 2, 5);
        access('h000000, 1'b0, 8'h0F, "R3 R6 dram0 miss");
        access('h000000, 1'b0, 8'hC0, "R7 dram0 hit");
        access('h000000, 1'b1, 8'h5A, "R7 R9 dram0 write hit");
        access('h001000, 1'b0, 8'hFF, "R6 new row miss");
        access('h400000, 1'b1, 8'h81, "R3 R8 dram1 bank switch");
        access('h001000, 1'b0, 8'h01, "R8 back to dram0 miss");
        access('h800000, 1'b0, 8'h0C, "R3 R5 cartridge");
        access('hDFF000, 1'b0, 8'h10, "R3 cartridge top");
        access('h001000, 1'b0, 8'h01, "R8 miss after rom");
        access('hE00000, 1'b0, 8'hFF, "R3 boot bank");
        access('h7FF000, 1'b0, 8'hFF, "R3 dram1 top");
        access('h7FF000, 1'b1, 8'h0F, "R7 dram1 hit write");

        // R4 layout, row field below minimum, zero read-only wait
        configure(1'b0, 0, 1);
        access('h000000, 1'b0, 8'hFF, "R4 R5 boot W0");
        access('h200000, 1'b0, 8'hF0, "R4 cartridge low");
        access('h7FF000, 1'b1, 8'hFF, "R4 R9 cartridge write");
        access('h800000, 1'b0, 8'h02, "R4 R6 dram1 min delay");
        access('h800000, 1'b0, 8'h08, "R7 dram1 hit");
        configure(1'b0, 0, 7);
        access('h800000, 1'b0, 8'h08, "R8 miss after cfg R6 delay7");
        access('hC00000, 1'b1, 8'h3C, "R4 dram0 write");
        access('hFFF000, 1'b0, 8'hFF, "R4 R6 dram0 other row");
        access('hFFF000, 1'b0, 8'h00, "R10 no bytes hit");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule